// File: doc/BRIEF.md
# Softened Pairwise Gravity Force Pipeline

This block sums the gravitational pull of a stream of source particles on one target particle. A start pulse loads the target position and a softening term and clears three signed accumulators. Source particles then arrive one per cycle, each with a position and a mass. Every source travels down a fixed eight-stage fused datapath. The datapath forms the displacement, the softened squared distance, an approximate reciprocal square root and its cube, and a scalar force factor. It then adds factor-times-displacement into the x, y and z accumulators.

Precision is deliberately coarse, about eight bits of relative accuracy. The reciprocal square root is built in three steps. The squared distance is normalised to an even power of two. Six leading bits then address a 64-entry table, and the power of two is undone by a shift. The caller marks the final source of a batch. A done flag rises when that source has reached the accumulators, and the sums are read directly from the output ports.

Top module: `gforce_pipe`

## Requirements
- R1: After reset, `done` is 0, all three accumulators read 0 and `src_ready` is 1.
- R2: A cycle with `start` high loads the target position and softening value, zeroes the accumulators, drops `done`, and discards every source still inside the pipeline.
- R3: For each accepted source the displacement per axis is d = source − target (signed). The squared distance is r2 = dx² + dy² + dz² + eps.
- R4: The reciprocal square root works on r2 as follows. p is the bit position of the most significant one of r2. e is p rounded down to an even number. The table index is idx = floor(r2·16 / 2^e), which lies in 16..63. The table value is T = floor(sqrt(floor(2^20 / idx))), which lies in 129..256.
- R5: The force factor is fac = floor(mass·T³ / 2^(3e/2)). The contribution on each axis is floor(fac·d / 2^16), rounded toward minus infinity.
- R6: Each accumulator adds the contributions of all accepted sources. It saturates at the signed limits of an ACC_W-bit word, and it can move back from a limit when later contributions have the opposite sign.
- R7: A source whose r2 is zero (coincident with the target, zero softening) changes no accumulator. Its last flag still completes the batch.
- R8: `done` becomes visible exactly 8 cycles after the clock edge that accepts the source flagged last. It stays high, with the accumulators holding their values, until the next start.
- R9: `src_ready` is low only in a start cycle. A source is taken on every edge where `src_valid` and `src_ready` are both high, so back-to-back input runs at one source per cycle. Cycles with `src_valid` low contribute nothing, whatever the source bus carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load target, clear sums, flush pipeline |
| tgt_x | input | 12 | Target x position, signed |
| tgt_y | input | 12 | Target y position, signed |
| tgt_z | input | 12 | Target z position, signed |
| soft_eps | input | 24 | Softening term added to r2, unsigned |
| src_valid | input | 1 | Source present on the bus |
| src_ready | output | 1 | Source can be accepted this cycle |
| src_x | input | 12 | Source x position, signed |
| src_y | input | 12 | Source y position, signed |
| src_z | input | 12 | Source z position, signed |
| src_mass | input | 8 | Source mass, unsigned |
| src_last | input | 1 | Marks the final source of a batch |
| acc_x | output | ACC_W | Accumulated x acceleration, signed |
| acc_y | output | ACC_W | Accumulated y acceleration, signed |
| acc_z | output | ACC_W | Accumulated z acceleration, signed |
| done | output | 1 | Batch result complete |

## Verification
The first stimulus is a single unit-distance, full-mass source at the origin, which shows whether the table end-point and the output scaling are right. Mixed-sign clustered sources with softening, and far sources whose squared distance has an odd leading-one position, separate the even-exponent normalisation and floor rounding from simpler variants. Long runs of identical close sources drive the accumulators into both saturation limits and back again. A coincident source, idle cycles carrying garbage data, and a start issued while sources are in flight show that nothing leaks into the sums.

// File: rtl/gforce_pkg.sv
package gforce_pkg;

    localparam int POS_W     = 12;
    localparam int MASS_W    = 8;
    localparam int EPS_W     = 24;
    localparam int IDX_W     = 6;
    localparam int LUT_F     = 8;
    localparam int OUT_SHIFT = 16;
    localparam int N_AXES    = 3;
    localparam int PIPE_LAT  = 8;

    localparam int D_W    = POS_W + 1;
    localparam int SQ_W   = 2 * D_W;
    localparam int R2_W   = SQ_W + 2;
    localparam int LUT_N  = 1 << IDX_W;
    localparam int RS_W   = LUT_F + 1;
    localparam int T2_W   = 2 * RS_W;
    localparam int CUBE_W = 3 * RS_W;
    localparam int FAC_W  = MASS_W + CUBE_W;
    localparam int PROD_W = FAC_W + D_W + 1;
    localparam int EXP_W  = $clog2(R2_W);
    localparam int LUT_NUM_SH = 2 * LUT_F + IDX_W - 2;

    typedef logic [N_AXES-1:0][D_W-1:0] disp_vec_t;

    typedef struct packed {
        logic              vld;
        logic              last;
        logic [MASS_W-1:0] mass;
        disp_vec_t         d;
    } src_item_t;

    typedef struct packed {
        src_item_t        s;
        logic             zero;
        logic [EXP_W-1:0] half_e;
    } norm_item_t;

    function automatic int unsigned isqrt_floor(input int unsigned v);
        int unsigned r;
        r = 0;
        for (int b = 15; b >= 0; b--) begin
            if ((r | (32'd1 << b)) * (r | (32'd1 << b)) <= v)
                r = r | (32'd1 << b);
        end
        return r;
    endfunction

    function automatic int unsigned lut_entry(input int unsigned i);
        if (i == 0)
            return 0;
        return isqrt_floor((32'd1 << LUT_NUM_SH) / i);
    endfunction

    function automatic int unsigned msb_pos(input logic [R2_W-1:0] v);
        int unsigned p;
        p = 0;
        for (int i = 0; i < R2_W; i++)
            if (v[i]) p = i;
        return p;
    endfunction

    function automatic logic [IDX_W-1:0] mant_index(input logic [R2_W-1:0] v,
                                                    input int unsigned e);
        logic [IDX_W-1:0] r;
        int pos;
        for (int i = 0; i < IDX_W; i++) begin
            pos = int'(e) - (IDX_W - 2) + i;
            r[i] = (pos >= 0 && pos < R2_W) ? v[pos] : 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/gforce_geom.sv
module gforce_geom
    import gforce_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic                           in_vld,
    input  logic                           in_last,
    input  logic [MASS_W-1:0]              in_mass,
    input  logic [N_AXES-1:0][POS_W-1:0]   src_pos,
    input  logic [N_AXES-1:0][POS_W-1:0]   tgt_pos,
    input  logic [EPS_W-1:0]               eps,
    output src_item_t                      out_item,
    output logic [R2_W-1:0]                out_r2
);

    disp_vec_t                      d_c;
    logic [N_AXES-1:0][SQ_W-1:0]    sq_c;
    logic [R2_W-1:0]                r2_c;
    src_item_t                      s1_q, s2_q;
    logic [R2_W-1:0]                r2_q;

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        logic signed [SQ_W-1:0] de;
        assign d_c[a] = D_W'($signed(src_pos[a])) - D_W'($signed(tgt_pos[a]));
        assign de     = SQ_W'($signed(s1_q.d[a]));
        assign sq_c[a] = de * de;
    end

    always_comb begin
        r2_c = R2_W'(eps);
        for (int a = 0; a < N_AXES; a++)
            r2_c = r2_c + R2_W'(sq_c[a]);
    end

    always_ff @(posedge clk) begin
        s1_q.last <= in_last;
        s1_q.mass <= in_mass;
        s1_q.d    <= d_c;
        s1_q.vld  <= in_vld && !flush;
        s2_q      <= s1_q;
        s2_q.vld  <= s1_q.vld && !flush;
        r2_q      <= r2_c;
        if (rst) begin
            s1_q.vld <= 1'b0;
            s2_q.vld <= 1'b0;
        end
    end

    assign out_item = s2_q;
    assign out_r2   = r2_q;

endmodule

// File: rtl/gforce_rsqrt.sv
module gforce_rsqrt
    import gforce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  src_item_t         in_item,
    input  logic [R2_W-1:0]   in_r2,
    output norm_item_t        out_item,
    output logic [CUBE_W-1:0] out_cube
);

    logic [RS_W-1:0] lut [LUT_N];

    for (genvar i = 0; i < LUT_N; i++) begin : g_lut
        assign lut[i] = RS_W'(lut_entry(i));
    end

    int unsigned       p_c, e_c;
    logic [IDX_W-1:0]  idx_c;
    norm_item_t        n_c;

    always_comb begin
        p_c   = msb_pos(in_r2);
        e_c   = p_c & ~32'd1;
        idx_c = mant_index(in_r2, e_c);
        n_c.s      = in_item;
        n_c.zero   = (in_r2 == '0);
        n_c.half_e = EXP_W'(e_c >> 1);
    end

    norm_item_t        s3_q, s4_q, s5_q, s6_q;
    logic [IDX_W-1:0]  idx_q;
    logic [RS_W-1:0]   t_q;
    logic [T2_W-1:0]   t2_q;
    logic [RS_W-1:0]   t5_q;
    logic [CUBE_W-1:0] cube_q;

    always_ff @(posedge clk) begin
        s3_q   <= n_c;
        idx_q  <= idx_c;
        s4_q   <= s3_q;
        t_q    <= lut[idx_q];
        s5_q   <= s4_q;
        t2_q   <= T2_W'(t_q) * T2_W'(t_q);
        t5_q   <= t_q;
        s6_q   <= s5_q;
        cube_q <= CUBE_W'(t2_q) * CUBE_W'(t5_q);
        s3_q.s.vld <= n_c.s.vld  && !flush;
        s4_q.s.vld <= s3_q.s.vld && !flush;
        s5_q.s.vld <= s4_q.s.vld && !flush;
        s6_q.s.vld <= s5_q.s.vld && !flush;
        if (rst) begin
            s3_q.s.vld <= 1'b0;
            s4_q.s.vld <= 1'b0;
            s5_q.s.vld <= 1'b0;
            s6_q.s.vld <= 1'b0;
        end
    end

    assign out_item = s6_q;
    assign out_cube = cube_q;

    // R4: a nonzero squared distance always lands inside the normalised table span
    p_lut_range_r4: assert property (@(posedge clk) disable iff (rst)
        (s4_q.s.vld && !s4_q.zero) |->
        (t_q > RS_W'(1 << (LUT_F - 1)) && t_q <= RS_W'(1 << LUT_F)));

endmodule

// File: rtl/gforce_scale.sv
module gforce_scale
    import gforce_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            flush,
    input  norm_item_t                      in_item,
    input  logic [CUBE_W-1:0]               in_cube,
    output logic                            out_vld,
    output logic                            out_last,
    output logic                            out_zero,
    output logic [N_AXES-1:0][PROD_W-1:0]   out_contrib
);

    logic [FAC_W-1:0] mc_c;
    logic [FAC_W-1:0] fac_c;

    always_comb begin
        mc_c  = FAC_W'(in_item.s.mass) * FAC_W'(in_cube);
        fac_c = mc_c >> (3 * int'(in_item.half_e));
    end

    norm_item_t        s7_q;
    logic [FAC_W-1:0]  fac_q;
    logic              v8_q, l8_q, z8_q;
    logic [N_AXES-1:0][PROD_W-1:0] c8_q;

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        logic signed [PROD_W-1:0] fs, ds, prod;
        assign fs   = PROD_W'($signed({1'b0, fac_q}));
        assign ds   = PROD_W'($signed(s7_q.s.d[a]));
        assign prod = fs * ds;
        always_ff @(posedge clk)
            c8_q[a] <= prod >>> OUT_SHIFT;
    end

    always_ff @(posedge clk) begin
        s7_q     <= in_item;
        fac_q    <= fac_c;
        l8_q     <= s7_q.s.last;
        z8_q     <= s7_q.zero;
        s7_q.s.vld <= in_item.s.vld && !flush;
        v8_q       <= s7_q.s.vld && !flush;
        if (rst) begin
            s7_q.s.vld <= 1'b0;
            v8_q       <= 1'b0;
        end
    end

    assign out_vld     = v8_q;
    assign out_last    = l8_q;
    assign out_zero    = z8_q;
    assign out_contrib = c8_q;

endmodule

// File: rtl/gforce_acc.sv
module gforce_acc
    import gforce_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clear,
    input  logic                            in_vld,
    input  logic                            in_last,
    input  logic [N_AXES-1:0][PROD_W-1:0]   in_contrib,
    output logic [N_AXES-1:0][ACC_W-1:0]    acc,
    output logic                            done
);

    localparam logic signed [PROD_W:0] MAXV = (PROD_W+1)'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
    localparam logic signed [PROD_W:0] MINV = -MAXV - (PROD_W+1)'(1);

    logic done_q;

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        logic signed [ACC_W-1:0]  acc_q;
        logic signed [PROD_W:0]   sum_c;
        logic signed [ACC_W-1:0]  nxt_c;

        assign sum_c = (PROD_W+1)'($signed(in_contrib[a])) + (PROD_W+1)'(acc_q);

        always_comb begin
            if (sum_c > MAXV)
                nxt_c = ACC_W'(MAXV);
            else if (sum_c < MINV)
                nxt_c = ACC_W'(MINV);
            else
                nxt_c = ACC_W'(sum_c);
        end

        always_ff @(posedge clk) begin
            if (rst || clear)
                acc_q <= '0;
            else if (in_vld)
                acc_q <= nxt_c;
        end

        assign acc[a] = acc_q;

        // R6: once at the upper limit, a non-negative contribution keeps it there
        p_sat_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (in_vld && !clear && acc_q == ACC_W'(MAXV) && !in_contrib[a][PROD_W-1])
            |=> (acc_q == ACC_W'(MAXV)));

        // R2: a start empties the accumulator
        p_clear_acc_r2: assert property (@(posedge clk) disable iff (rst)
            clear |=> (acc_q == '0));
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            done_q <= 1'b0;
        else if (in_vld && in_last)
            done_q <= 1'b1;
    end

    assign done = done_q;

    // R2: a start drops the completion flag
    p_clear_done_r2: assert property (@(posedge clk) disable iff (rst)
        clear |=> !done_q);

endmodule

// File: rtl/gforce_pipe.sv
module gforce_pipe
    import gforce_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [POS_W-1:0]    tgt_x,
    input  logic [POS_W-1:0]    tgt_y,
    input  logic [POS_W-1:0]    tgt_z,
    input  logic [EPS_W-1:0]    soft_eps,
    input  logic                src_valid,
    output logic                src_ready,
    input  logic [POS_W-1:0]    src_x,
    input  logic [POS_W-1:0]    src_y,
    input  logic [POS_W-1:0]    src_z,
    input  logic [MASS_W-1:0]   src_mass,
    input  logic                src_last,
    output logic [ACC_W-1:0]    acc_x,
    output logic [ACC_W-1:0]    acc_y,
    output logic [ACC_W-1:0]    acc_z,
    output logic                done
);

    logic [N_AXES-1:0][POS_W-1:0] tgt_q;
    logic [EPS_W-1:0]             eps_q;
    logic [N_AXES-1:0][POS_W-1:0] src_pos;
    logic                         accept;

    assign src_ready = !start;
    assign accept    = src_valid && src_ready;
    assign src_pos   = {src_z, src_y, src_x};

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
            eps_q <= '0;
        end else if (start) begin
            tgt_q <= {tgt_z, tgt_y, tgt_x};
            eps_q <= soft_eps;
        end
    end

    src_item_t                     geo_item;
    logic [R2_W-1:0]               geo_r2;
    norm_item_t                    nrm_item;
    logic [CUBE_W-1:0]             nrm_cube;
    logic                          sc_vld, sc_last, sc_zero;
    logic [N_AXES-1:0][PROD_W-1:0] sc_contrib;
    logic [N_AXES-1:0][ACC_W-1:0]  acc_v;

    gforce_geom u_geom (
        .clk      (clk),
        .rst      (rst),
        .flush    (start),
        .in_vld   (accept),
        .in_last  (src_last),
        .in_mass  (src_mass),
        .src_pos  (src_pos),
        .tgt_pos  (tgt_q),
        .eps      (eps_q),
        .out_item (geo_item),
        .out_r2   (geo_r2)
    );

    gforce_rsqrt u_rsqrt (
        .clk      (clk),
        .rst      (rst),
        .flush    (start),
        .in_item  (geo_item),
        .in_r2    (geo_r2),
        .out_item (nrm_item),
        .out_cube (nrm_cube)
    );

    gforce_scale u_scale (
        .clk         (clk),
        .rst         (rst),
        .flush       (start),
        .in_item     (nrm_item),
        .in_cube     (nrm_cube),
        .out_vld     (sc_vld),
        .out_last    (sc_last),
        .out_zero    (sc_zero),
        .out_contrib (sc_contrib)
    );

    gforce_acc #(.ACC_W(ACC_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .in_vld     (sc_vld),
        .in_last    (sc_last),
        .in_contrib (sc_contrib),
        .acc        (acc_v),
        .done       (done)
    );

    assign acc_x = acc_v[0];
    assign acc_y = acc_v[1];
    assign acc_z = acc_v[2];

    // R7: a coincident source leaves every sum untouched
    p_zero_src_r7: assert property (@(posedge clk) disable iff (rst)
        (sc_vld && sc_zero && !start) |=>
        ($stable(acc_x) && $stable(acc_y) && $stable(acc_z)));

    // R8: completion only follows the flagged source leaving the last stage
    p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(sc_vld && sc_last));

    // R8: after completion the sums hold until the next start
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(acc_x) && $stable(acc_y) && $stable(acc_z)));

endmodule

// File: tb/gforce_pipe_test.sv
`timescale 1ns/1ps
module gforce_pipe_test;

    localparam int     AW   = 20;
    localparam longint AMAX = (64'sd1 <<< (AW - 1)) - 1;
    localparam longint AMIN = -AMAX - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst, start, src_valid, src_ready, src_last, done;
    logic [11:0]      tgt_x, tgt_y, tgt_z, src_x, src_y, src_z;
    logic [23:0]      soft_eps;
    logic [7:0]       src_mass;
    logic [AW-1:0]    acc_x, acc_y, acc_z;

    gforce_pipe #(.ACC_W(AW)) uut (
        .clk(clk), .rst(rst), .start(start),
        .tgt_x(tgt_x), .tgt_y(tgt_y), .tgt_z(tgt_z), .soft_eps(soft_eps),
        .src_valid(src_valid), .src_ready(src_ready),
        .src_x(src_x), .src_y(src_y), .src_z(src_z),
        .src_mass(src_mass), .src_last(src_last),
        .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z), .done(done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    typedef struct { longint ax; longint ay; longint az; int edge_n; } exp_t;
    exp_t sb[$];

    longint m_t[3];
    longint m_eps;
    longint m_acc[3];

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    function automatic longint contrib(input longint d0, input longint d1, input longint d2,
                                       input longint eps, input longint mass, input longint dsel);
        longint r2, idx, v, t, cube, fac;
        int p, e;
        r2 = d0*d0 + d1*d1 + d2*d2 + eps;
        if (r2 == 0) return 0;
        p = 0;
        for (int i = 0; i < 40; i++) if (((r2 >> i) & 1) == 1) p = i;
        e   = p - (p % 2);
        idx = (r2 * 16) >> e;
        v   = (64'sd1 <<< 20) / idx;
        t   = 0;
        while ((t + 1) * (t + 1) <= v) t++;
        cube = t * t * t;
        fac  = (mass * cube) >>> (3 * (e / 2));
        return (fac * dsel) >>> 16;
    endfunction

    function automatic longint sat_add(input longint a, input longint b);
        longint s;
        s = a + b;
        if (s > AMAX) return AMAX;
        if (s < AMIN) return AMIN;
        return s;
    endfunction

    function automatic longint sx(input logic [AW-1:0] v);
        return longint'($signed(v));
    endfunction

    // driver: clears the model on start (R2) and checks the handshake (R9)
    task automatic start_batch(input int tx, input int ty, input int tz, input int eps);
        @(negedge clk);
        start = 1'b1;
        tgt_x = 12'(tx); tgt_y = 12'(ty); tgt_z = 12'(tz);
        soft_eps = 24'(eps);
        src_valid = 1'b1; src_x = 12'd7; src_y = 12'd9; src_z = 12'd3;
        src_mass = 8'd200; src_last = 1'b1;
        #1;
        chk("R9 ready low in start cycle", longint'(src_ready), 0);
        @(posedge clk);
        #1;
        start = 1'b0; src_valid = 1'b0; src_last = 1'b0;
        chk("R2 done cleared", longint'(done), 0);
        chk("R2 acc_x cleared", sx(acc_x), 0);
        chk("R2 acc_y cleared", sx(acc_y), 0);
        chk("R2 acc_z cleared", sx(acc_z), 0);
        m_t[0] = tx; m_t[1] = ty; m_t[2] = tz; m_eps = eps;
        m_acc[0] = 0; m_acc[1] = 0; m_acc[2] = 0;
    endtask

    task automatic send(input int px, input int py, input int pz, input int m, input bit last);
        longint d[3];
        exp_t e;
        @(negedge clk);
        src_valid = 1'b1; src_last = last;
        src_x = 12'(px); src_y = 12'(py); src_z = 12'(pz); src_mass = 8'(m);
        d[0] = px - m_t[0]; d[1] = py - m_t[1]; d[2] = pz - m_t[2];
        for (int a = 0; a < 3; a++)
            m_acc[a] = sat_add(m_acc[a], contrib(d[0], d[1], d[2], m_eps, m, d[a]));
        if (last) begin
            e.ax = m_acc[0]; e.ay = m_acc[1]; e.az = m_acc[2]; e.edge_n = cyc + 1;
            sb.push_back(e);
        end
        @(posedge clk);
        #1;
        src_valid = 1'b0; src_last = 1'b0;
    endtask

    // R9: idle cycles with junk on the source bus
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_valid = 1'b0; src_x = 12'(i * 37 + 5); src_y = 12'(-i * 11);
            src_z = 12'd1; src_mass = 8'd255; src_last = 1'b1;
        end
        @(negedge clk);
        src_last = 1'b0;
    endtask

    task automatic drain_and_hold();
        while (sb.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R8 done held", longint'(done), 1);
        chk("R8 acc_x held", sx(acc_x), m_acc[0]);
        chk("R8 acc_y held", sx(acc_y), m_acc[1]);
        chk("R8 acc_z held", sx(acc_z), m_acc[2]);
    endtask

    // monitor: pops the scoreboard on each rising done
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            done_prev = 1'b0;
        end else begin
            if (done && !done_prev) begin
                if (sb.size() == 0) begin
                    chk("R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk("R5 R6 acc_x", sx(acc_x), e.ax);
                    chk("R5 R6 acc_y", sx(acc_y), e.ay);
                    chk("R5 R6 acc_z", sx(acc_z), e.az);
                    chk("R8 latency", longint'(cyc), longint'(e.edge_n + 8));
                end
            end
            done_prev = done;
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R8 watchdog act=%0d exp=below 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; src_valid = 1'b0; src_last = 1'b0;
        tgt_x = '0; tgt_y = '0; tgt_z = '0; soft_eps = '0;
        src_x = '0; src_y = '0; src_z = '0; src_mass = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", longint'(done), 0);
        chk("R1 acc_x", sx(acc_x), 0);
        chk("R1 acc_y", sx(acc_y), 0);
        chk("R1 acc_z", sx(acc_z), 0);
        chk("R1 ready", longint'(src_ready), 1);

        // R4 R5: unit distance, full mass: table top entry, value 65280 on x
        start_batch(0, 0, 0, 0);
        send(1, 0, 0, 255, 1'b1);
        drain_and_hold();
        chk("R5 unit source", sx(acc_x), 65280);

        // R3 R4: clustered mixed-sign sources with softening, back to back
        start_batch(100, -50, 20, 64);
        send(103, -50, 18, 120, 1'b0);
        send(95, -44, 27, 33, 1'b0);
        send(100, -50, 20, 250, 1'b0);
        send(130, -90, 60, 7, 1'b0);
        send(60, -20, 25, 180, 1'b0);
        send(101, -51, 21, 90, 1'b1);
        drain_and_hold();

        // R4: distant sources, odd and even leading-one positions
        start_batch(-2000, 1500, 0, 3);
        send(2000, -2000, 2047, 255, 1'b0);
        send(-1000, 1000, -300, 128, 1'b0);
        send(-1990, 1512, 40, 77, 1'b0);
        send(0, 0, 0, 200, 1'b1);
        drain_and_hold();

        // R7 R9: coincident source between ordinary ones, junk in idle gaps
        start_batch(5, 5, 5, 0);
        send(9, 2, 5, 150, 1'b0);
        idle(3);
        send(5, 5, 5, 255, 1'b0);
        idle(2);
        send(5, 5, 5, 99, 1'b1);
        drain_and_hold();
        chk("R7 x only first source", sx(acc_x), contrib(4, -3, 0, 0, 150, 4));

        // R6: drive x to the upper limit and y to the lower, then step back
        start_batch(0, 0, 0, 0);
        for (int i = 0; i < 30; i++) send(1, -1, 0, 255, 1'b0);
        send(-1, 0, 0, 255, 1'b1);
        drain_and_hold();
        chk("R6 x backed off max", sx(acc_x), AMAX - 65280);
        chk("R6 y at min", sx(acc_y), AMIN);

        // R2: start while sources are in flight drops them
        start_batch(0, 0, 0, 0);
        send(1, 0, 0, 255, 1'b0);
        send(0, 1, 0, 255, 1'b0);
        send(0, 0, 1, 255, 1'b0);
        start_batch(10, 10, 10, 16);
        send(12, 8, 10, 40, 1'b1);
        drain_and_hold();
        chk("R2 flushed batch", sx(acc_x), contrib(2, -2, 0, 16, 40, 2));

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule